// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Auto-Reload

This block is a 32-bit down counter behind a small synchronous register port. Software programs a reload value, optionally overwrites the live count, selects a prescale divisor and chooses between a single-shot run and a periodic, self-reloading run. Every time the count runs out, a sticky event flag is raised. That flag drives a level interrupt, which an enable bit can mask.

Each clock edge is one base tick. The counter steps down once every P+1 base ticks, where P is the 8-bit prescale field. Several zero-value rules decide whether the counter may run. With P equal to zero, a counter that would sit at zero with nothing to reload either refuses to start or stops itself after its next expiry. Any write to the reload, count or control register restarts the prescale phase from zero. The port takes whole 32-bit words only. Reads return data one cycle after the request.

Top module: `cdt_timer`

## Requirements
- R1: After reset, the reload, count, control and status registers all read zero, irq_o is low, and the counter is stopped.
- R2: Word address 0x0 holds the reload value, 0x4 the live count, 0x8 the control word and 0xC the status word. A write to 0x0 sets both the reload value and the live count to the written data.
- R3: Control bit 0 is run enable and bits 15:8 are the prescale P. While the counter runs, it decrements once every P+1 clock edges, with the phase counted from the edge of the last write to 0x0, 0x4 or 0x8.
- R4: When the count reaches zero on a decrement, status bit 0 is set. irq_o equals status bit 0 AND control bit 2 (interrupt enable), so with bit 2 clear irq_o stays low while status reads 1.
- R5: Status bit 0 is write-one-to-clear. A write of 1 to 0xC clears it and drops irq_o from the next cycle on. A write of 0 leaves it set. An expiry in the same cycle wins over a clear.
- R6: With control bit 1 (auto-reload) clear, the counter stops once it expires and raises no further events.
- R7: With auto-reload set, a tick taken at count zero loads the reload value, so one period spans reload+1 decrements.
- R8: The counter runs only while enable is set AND (P is nonzero OR the value just placed in the count is nonzero).
- R9: With auto-reload set and P zero, writing 0 to the count register places the reload value in the count instead.
- R10: With auto-reload set, P zero and a reload value of zero, the counter stops itself after its next expiry.
- R11: A control write that clears enable freezes the count. A control write that sets enable together with auto-reload while the count is zero first loads the reload value into the count.
- R12: A write to an address that is not 0x0, 0x4, 0x8 or 0xC (including unaligned and out-of-range addresses) changes nothing, and a read of such an address returns zero.

Control reads return enable in bit 0, auto-reload in bit 1, interrupt enable in bit 2 and P in bits 15:8, with all other bits zero. Status reads return the flag in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; each rising edge is one base tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt: status flag AND interrupt enable |

## Verification
A corrupted count or prescale phase shows up at the ports as an expiry on the wrong edge. For that reason, the directed scenarios sample irq_o and status on the exact edge that the P+1 arithmetic predicts and on the edge before it. This exposes an off-by-one within a single tick. A wrong run flag is harder to see, because a stopped counter and a counter spinning at zero both read 0. Each stop rule is therefore checked by clearing the flag and watching several edges for a spurious fresh expiry. A lost reload or a lost zero-substitution shows up in the count read back one cycle after the write that caused it.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_idx_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_AR_BIT  = 1;
  localparam int unsigned CTRL_IE_BIT  = 2;
  localparam int unsigned CTRL_PRE_LSB = 8;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] phase_q;

  assign tick_o = run_i && !clr_i && (phase_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= '0;
    else if (clr_i || !run_i)    phase_q <= '0;
    else if (phase_q == presc_i) phase_q <= '0;
    else                         phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic              stat_i,
  output logic              wr_load_o,
  output logic              wr_count_o,
  output logic              wr_ctrl_o,
  output logic              wr_stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic     hit;
  reg_idx_e idx;
  logic [DATA_W-1:0] rd_mux;

  // only aligned words inside the 16-byte window decode
  assign hit = (addr_i[1:0] == 2'b00) && ((addr_i >> 4) == '0);
  assign idx = reg_idx_e'(addr_i[3:2]);

  assign wr_load_o  = req_i && we_i && hit && (idx == REG_LOAD);
  assign wr_count_o = req_i && we_i && hit && (idx == REG_COUNT);
  assign wr_ctrl_o  = req_i && we_i && hit && (idx == REG_CTRL);
  assign wr_stat_o  = req_i && we_i && hit && (idx == REG_STAT);

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (idx)
        REG_LOAD:  rd_mux = load_i;
        REG_COUNT: rd_mux = count_i;
        REG_CTRL:  rd_mux = ctrl_i;
        REG_STAT:  rd_mux = {{(DATA_W-1){1'b0}}, stat_i};
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_load_i,
  input  logic              wr_count_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] count_o,
  output logic              en_o,
  output logic              ar_o,
  output logic              ie_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic              running_o,
  output logic              status_o,
  output logic              expire_o
);
  logic              wr_any;
  logic [DATA_W-1:0] cnt_wr_val, cnt_en_val, cnt_next;
  logic              new_en, new_ar, new_ie;
  logic [PRE_W-1:0]  new_presc;

  assign wr_any    = wr_load_i || wr_count_i || wr_ctrl_i;
  assign new_en    = wdata_i[CTRL_EN_BIT];
  assign new_ar    = wdata_i[CTRL_AR_BIT];
  assign new_ie    = wdata_i[CTRL_IE_BIT];
  assign new_presc = wdata_i[CTRL_PRE_LSB +: PRE_W];

  // zero count write in auto-reload with no prescale takes the reload value
  assign cnt_wr_val = (ar_o && presc_o == '0 && wdata_i == '0) ? load_o : wdata_i;
  // enabling auto-reload on an empty count reloads first
  assign cnt_en_val = (new_ar && count_o == '0) ? load_o : count_o;
  assign cnt_next   = (count_o == '0) ? (ar_o ? load_o : '0) : count_o - 1'b1;
  assign expire_o   = tick_i && !wr_any && (cnt_next == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o    <= '0;
      count_o   <= '0;
      en_o      <= 1'b0;
      ar_o      <= 1'b0;
      ie_o      <= 1'b0;
      presc_o   <= '0;
      running_o <= 1'b0;
    end else if (wr_load_i) begin
      load_o    <= wdata_i;
      count_o   <= wdata_i;
      running_o <= en_o && (presc_o != '0 || wdata_i != '0);
    end else if (wr_count_i) begin
      count_o   <= cnt_wr_val;
      running_o <= en_o && (presc_o != '0 || cnt_wr_val != '0);
    end else if (wr_ctrl_i) begin
      en_o    <= new_en;
      ar_o    <= new_ar;
      ie_o    <= new_ie;
      presc_o <= new_presc;
      if (new_en) begin
        count_o   <= cnt_en_val;
        running_o <= (new_presc != '0) || (cnt_en_val != '0);
      end else begin
        running_o <= 1'b0;
      end
    end else if (tick_i) begin
      count_o <= cnt_next;
      if (expire_o && (!ar_o || (presc_o == '0 && load_o == '0)))
        running_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      status_o <= 1'b0;
    else if (expire_o)                status_o <= 1'b1;
    else if (wr_stat_i && wdata_i[0]) status_o <= 1'b0;
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - CTRL_PRE_LSB - PRE_W;

  logic              wr_load, wr_count, wr_ctrl, wr_stat, wr_any;
  logic              tick, running, status, expire;
  logic              en, ar, ie;
  logic [PRE_W-1:0]  presc;
  logic [DATA_W-1:0] load, count, ctrl_rd;

  assign wr_any  = wr_load || wr_count || wr_ctrl;
  assign ctrl_rd = {{PAD_W{1'b0}}, presc, 5'b0, ie, ar, en};
  assign irq_o   = status && ie;

  cdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .load_i(load), .count_i(count), .ctrl_i(ctrl_rd), .stat_i(status),
    .wr_load_o(wr_load), .wr_count_o(wr_count),
    .wr_ctrl_o(wr_ctrl), .wr_stat_o(wr_stat),
    .rdata_o
  );

  cdt_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk_i, .rst_ni, .run_i(running), .clr_i(wr_any),
    .presc_i(presc), .tick_o(tick)
  );

  cdt_core #(.DATA_W(DATA_W), .PRE_W(PRE_W)) i_core (
    .clk_i, .rst_ni,
    .wr_load_i(wr_load), .wr_count_i(wr_count),
    .wr_ctrl_i(wr_ctrl), .wr_stat_i(wr_stat),
    .wdata_i, .tick_i(tick),
    .load_o(load), .count_o(count), .en_o(en), .ar_o(ar), .ie_o(ie),
    .presc_o(presc), .running_o(running), .status_o(status),
    .expire_o(expire)
  );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              wr_any,
  input logic              wr_stat,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load,
  input logic [PRE_W-1:0]  presc,
  input logic              running,
  input logic              status,
  input logic              expire,
  input logic              en,
  input logic              ar
);
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_any && count != '0) |=> (count == $past(count) - 1'b1));

  a_r6_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ar) |=> !running);

  a_r10_self_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && presc == '0 && load == '0) |=> !running);

  a_r5_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status && !(wr_stat && wdata_i[0])) |=> status);

  a_r8_run_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> en);
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W), .PRE_W(PRE_W)) i_chk (
  .clk_i, .rst_ni, .tick, .wr_any, .wr_stat, .wdata_i, .count, .load,
  .presc, .running, .status, .expire, .en, .ar
);

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C;

  always #4 clk_i = ~clk_i;

  cdt_timer i_cdt_timer (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic idle();
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(A_LOAD, v); chk("R1 load", v, 32'h0);
    rd(A_CNT, v);  chk("R1 count", v, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'h1234_5678);
    rd(A_LOAD, v); chk("R2 load", v, 32'h1234_5678);
    rd(A_CNT, v);  chk("R2 count", v, 32'h1234_5678);
    wr(A_CTRL, 32'h0000_AB07);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h0000_AB07);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_oneshot();
    idle();
    wr(A_LOAD, 32'h0);
    wr(A_CTRL, 32'h5);
    wr(A_LOAD, 32'd3);
    wait_n(2); chk("R4 irq before expiry", {31'b0, irq_o}, 32'h0);
    wait_n(1); chk("R4 irq at expiry", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h0); chk("R5 write 0 keeps", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h1); chk("R5 clear drops irq", {31'b0, irq_o}, 32'h0);
    wait_n(5); chk("R6 one-shot stays stopped", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h0000_0201);
    wait_n(5);
    rd(A_STAT, v); chk("R3 no expiry at 5 edges", v, 32'h0);
    rd(A_STAT, v); chk("R3 expiry at 6 edges", v, 32'h1);
    chk("R4 irq masked", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h7);
    wait_n(1); chk("R7 no early expiry", {31'b0, irq_o}, 32'h0);
    wait_n(1); chk("R7 first expiry", {31'b0, irq_o}, 32'h1);
    wait_n(1);
    rd(A_CNT, v); chk("R7 reloaded count", v, 32'd2);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_zero_gate();
    idle();
    wr(A_LOAD, 32'h0);
    wr(A_CTRL, 32'h5);
    wait_n(5); chk("R8 zero load no run", {31'b0, irq_o}, 32'h0);
    wr(A_CNT, 32'h0);
    wait_n(3); chk("R8 zero count no run", {31'b0, irq_o}, 32'h0);
    wr(A_CTRL, 32'h0000_0105);
    wait_n(1); chk("R8 P nonzero runs, not yet", {31'b0, irq_o}, 32'h0);
    wait_n(1); chk("R8 P nonzero expiry", {31'b0, irq_o}, 32'h1);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_subst();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'h3);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v); chk("R9 zero count takes reload", v, 32'd5);
  endtask

  task automatic t_selfstop();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'h0);
    wr(A_CTRL, 32'h7);
    wr(A_CNT, 32'd3);
    wait_n(2); chk("R10 no early expiry", {31'b0, irq_o}, 32'h0);
    wait_n(1); chk("R10 expiry", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h1);
    wait_n(5); chk("R10 stopped after expiry", {31'b0, irq_o}, 32'h0);
    rd(A_CNT, v); chk("R10 count zero", v, 32'h0);
  endtask

  task automatic t_ctrl_change();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'd100);
    wr(A_CTRL, 32'h0000_0301);
    wait_n(10);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v); chk("R11 count at disable", v, 32'd98);
    wait_n(10);
    rd(A_CNT, v); chk("R11 count frozen", v, 32'd98);
    wr(A_LOAD, 32'd7);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h0000_2003);
    rd(A_CNT, v); chk("R11 enable ar reloads", v, 32'd7);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    idle();
    wr(A_LOAD, 32'h55);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h10, v);  chk("R12 unmapped reads zero", v, 32'h0);
    rd(5'h09, v);  chk("R12 unaligned reads zero", v, 32'h0);
    rd(A_LOAD, v); chk("R12 load untouched", v, 32'h55);
    rd(A_CTRL, v); chk("R12 ctrl untouched", v, 32'h0);
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    t_reset();
    t_load();
    t_oneshot();
    t_prescale();
    t_reload();
    t_zero_gate();
    t_subst();
    t_selfstop();
    t_ctrl_change();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule